// File: doc/BRIEF.md
# Programmable Transmit Clock Phase Shifter

This block makes a 25 MHz transmit clock for a media-independent interface from a 250 MHz reference tick. A divide-by-ten counter produces a square wave that is high for five ticks and low for five ticks. The phase of that wave can be moved against a free-running alignment counter in 4 ns steps, one reference tick per step. The alignment counter wraps every ten ticks and shows each wrap on a sync output.

Software writes a 16-bit control word. Bits [4:0] hold the phase step count and bit 5 is a self-clearing apply flag. A step count above ten is folded to its remainder modulo ten when it is stored. The stored step count only moves the clock when a write sets the apply flag. The move then happens at the next wrap of the alignment counter. The apply flag reads back as 1 while the move is waiting. It reads back as 0 once the move has happened.

Top module: `txclk_phase_shifter`

## Requirements
- R1: After reset the read word is 0, and rising edges of `tx_clk_o` fall on the cycles where `align_o` is high (offset 0).
- R2: `tx_clk_o` has a period of 10 reference ticks, with 5 ticks high and 5 ticks low.
- R3: `align_o` is high for exactly one cycle in every 10 cycles.
- R4: Once a phase value P has been applied, every rising edge of `tx_clk_o` comes (P mod 10) cycles after the cycle where `align_o` is high.
- R5: A write stores the step count (bits [4:0]) folded as follows: values 0 to 10 are kept, and values above 10 become value mod 10. The read word shows the folded value in bits [4:0]. A stored 10 gives offset 0.
- R6: A write with bit 5 = 0 updates the stored step count but does not move `tx_clk_o`. The read word then shows bit 5 = 0.
- R7: After a write with bit 5 = 1, bit 5 of the read word is 1 until the next wrap of the alignment counter. It drops to 0 in the cycle where `align_o` is high, and the new phase applies from that cycle on.
- R8: Bits [15:6] of the read word are always 0, whatever value was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 250 MHz reference tick |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word: [4:0] step count, [5] apply flag, [15:6] unused |
| rd_data | output | 16 | Read word: [4:0] folded step count, [5] apply pending, [15:6] zero |
| tx_clk_o | output | 1 | Generated 25 MHz transmit clock |
| align_o | output | 1 | High in the cycle where the alignment counter is at zero |

## Verification
The main stimulus sweeps every step count from 0 to 31 through an apply write. For each one, the bench measures how many cycles the rising edge lags the sync pulse. This separates plain values from folded ones, and it shows the difference between the kept value 10 and the folded values 20 and 30. A write without the apply flag, made after a real shift, shows whether the stored field is kept apart from the applied phase. The bench watches the apply flag around a wrap to check that the clear and the phase change both happen on the wrap. A write with all unused bits set shows whether those bits are read back as zero.

// File: rtl/txps_pkg.sv
package txps_pkg;

    // Default geometry of the divider and the control word
    localparam int DIV_DEF       = 10;
    localparam int PH_W_DEF      = 5;
    localparam int REG_W_DEF     = 16;
    localparam int APPLY_BIT_DEF = 5;

    // Level of the generated clock
    typedef enum logic {
        CLK_LO = 1'b0,
        CLK_HI = 1'b1
    } clk_level_e;

    // Control state seen on the read port
    typedef struct packed {
        logic                pending;
        logic [PH_W_DEF-1:0] phase;
    } ctrl_state_t;

endpackage

// File: rtl/txps_align_counter.sv
module txps_align_counter #(
    parameter int DIV   = txps_pkg::DIV_DEF,
    parameter int CNT_W = $clog2(DIV)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = (cnt_q == '0);
    assign last_o = (cnt_q == LAST);

    // R3
    align_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(DIV));

    // R3
    align_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == LAST) |=> (cnt_q == '0));

endmodule

// File: rtl/txps_ctrl_regs.sv
module txps_ctrl_regs #(
    parameter int DIV       = txps_pkg::DIV_DEF,
    parameter int PH_W      = txps_pkg::PH_W_DEF,
    parameter int REG_W     = txps_pkg::REG_W_DEF,
    parameter int APPLY_BIT = txps_pkg::APPLY_BIT_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             at_last_i,
    output logic             load_o,
    output logic [PH_W-1:0]  phase_o,
    output logic [REG_W-1:0] rd_data
);
    localparam logic [PH_W-1:0] DIV_PH = PH_W'(DIV);

    logic [PH_W-1:0] ph_q;
    logic            pend_q;
    logic [PH_W-1:0] raw_ph;
    logic [PH_W-1:0] fold_ph;
    logic            wr_apply;

    assign raw_ph   = wr_data[PH_W-1:0];
    assign wr_apply = wr_en && wr_data[APPLY_BIT];

    // Values above the divider are reduced modulo the divider
    always_comb begin
        if (raw_ph > DIV_PH)
            fold_ph = raw_ph % DIV_PH;
        else
            fold_ph = raw_ph;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= '0;
            pend_q <= 1'b0;
        end else begin
            if (wr_en)
                ph_q <= fold_ph;
            if (wr_apply)
                pend_q <= 1'b1;
            else if (pend_q && at_last_i)
                pend_q <= 1'b0;
        end
    end

    assign load_o  = pend_q && at_last_i;
    assign phase_o = ph_q;

    always_comb begin
        rd_data             = '0;
        rd_data[PH_W-1:0]   = ph_q;
        rd_data[APPLY_BIT]  = pend_q;
    end

    // R5
    ph_range_chk: assert property (@(posedge clk) disable iff (rst)
        ph_q <= DIV_PH);

    // R7
    pend_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pend_q) |-> $past(at_last_i));

    // R6
    no_spont_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (!pend_q && !wr_apply) |=> !pend_q);

endmodule

// File: rtl/txps_phase_counter.sv
module txps_phase_counter #(
    parameter int DIV   = txps_pkg::DIV_DEF,
    parameter int PH_W  = txps_pkg::PH_W_DEF,
    parameter int CNT_W = $clog2(DIV)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [PH_W-1:0]  phase_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] offset_o,
    output logic             clk_o
);
    import txps_pkg::*;

    localparam int               HIGH = DIV / 2;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] off_q;
    logic [CNT_W-1:0] off_n;
    logic [CNT_W-1:0] start_n;
    clk_level_e       level;

    // Start count so that count zero lands on alignment count == offset
    always_comb begin
        off_n = CNT_W'(int'(phase_i) % DIV);
        if (off_n == '0)
            start_n = '0;
        else
            start_n = CNT_W'(DIV) - off_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            off_q <= '0;
        end else if (load_i) begin
            cnt_q <= start_n;
            off_q <= off_n;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign level    = (cnt_q < CNT_W'(HIGH)) ? CLK_HI : CLK_LO;
    assign clk_o    = (level == CLK_HI);
    assign cnt_o    = cnt_q;
    assign offset_o = off_q;

    // R2
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(DIV));

endmodule

// File: rtl/txclk_phase_shifter.sv
module txclk_phase_shifter #(
    parameter int DIV       = txps_pkg::DIV_DEF,
    parameter int PH_W      = txps_pkg::PH_W_DEF,
    parameter int REG_W     = txps_pkg::REG_W_DEF,
    parameter int APPLY_BIT = txps_pkg::APPLY_BIT_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             tx_clk_o,
    output logic             align_o
);
    localparam int CNT_W = $clog2(DIV);

    logic [CNT_W-1:0] a_cnt;
    logic [CNT_W-1:0] p_cnt;
    logic [CNT_W-1:0] applied_off;
    logic             a_last;
    logic             load;
    logic [PH_W-1:0]  stored_ph;

    txps_align_counter #(.DIV(DIV), .CNT_W(CNT_W)) u_align (
        .clk    (clk),
        .rst    (rst),
        .cnt_o  (a_cnt),
        .wrap_o (align_o),
        .last_o (a_last)
    );

    txps_ctrl_regs #(
        .DIV(DIV), .PH_W(PH_W), .REG_W(REG_W), .APPLY_BIT(APPLY_BIT)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .at_last_i (a_last),
        .load_o    (load),
        .phase_o   (stored_ph),
        .rd_data   (rd_data)
    );

    txps_phase_counter #(.DIV(DIV), .PH_W(PH_W), .CNT_W(CNT_W)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .phase_i  (stored_ph),
        .cnt_o    (p_cnt),
        .offset_o (applied_off),
        .clk_o    (tx_clk_o)
    );

    // R4
    rise_align_chk: assert property (@(posedge clk) disable iff (rst)
        (p_cnt == '0) |-> (a_cnt == applied_off));

    // R7
    load_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> align_o);

endmodule

// File: tb/txclk_phase_shifter_test.sv
module txclk_phase_shifter_test;
    localparam int CLK_PERIOD = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        tx_clk_o;
    logic        align_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int since = 0;
    int rise_off = -1;
    int hi_len = 0;
    int lo_len = 0;
    int run = 0;
    logic prev_clk = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txclk_phase_shifter uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tx_clk_o(tx_clk_o), .align_o(align_o)
    );

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (align_o) since = 0;
            else         since = since + 1;
            if (tx_clk_o && !prev_clk) rise_off = since;
            if (tx_clk_o == prev_clk) run = run + 1;
            else begin
                if (prev_clk) hi_len = run;
                else          lo_len = run;
                run = 1;
            end
            prev_clk = tx_clk_o;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    function automatic int fold(input int v);
        return (v > 10) ? v % 10 : v;
    endfunction

    task automatic write_word(input logic [15:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
        #1;
    endtask

    task automatic wait_applied(output bit wrap_seen);
        wrap_seen = 1'b0;
        for (int i = 0; i < 30; i++) begin
            if (rd_data[5] == 1'b0) begin
                wrap_seen = align_o;
                break;
            end
            tick(1);
        end
    endtask

    task automatic test_reset();
        rst = 1'b1;
        tick(4);
        rst = 1'b0;
        tick(1);
        check(rd_data == 16'h0, "R1 read word", int'(rd_data), 0);
        tick(30);
        check(rise_off == 0, "R1 reset offset", rise_off, 0);
        check(hi_len == 5, "R2 high ticks", hi_len, 5);
        check(lo_len == 5, "R2 low ticks", lo_len, 5);
    endtask

    task automatic test_sync_rate();
        int n = 0;
        for (int i = 0; i < 100; i++) begin
            tick(1);
            if (align_o) n++;
        end
        check(n == 10, "R3 sync pulses in 100 cycles", n, 10);
    endtask

    task automatic test_apply_timing();
        bit wrap_seen;
        write_word(16'h0024);
        check(rd_data[5] == 1'b1, "R7 pending after write", int'(rd_data[5]), 1);
        check(rise_off == 0, "R7 old phase while pending", rise_off, 0);
        wait_applied(wrap_seen);
        check(rd_data[5] == 1'b0, "R7 pending cleared", int'(rd_data[5]), 0);
        check(wrap_seen, "R7 clear on wrap", int'(wrap_seen), 1);
        tick(25);
        check(rise_off == 4, "R7 new offset after wrap", rise_off, 4);
    endtask

    task automatic test_sweep();
        bit wrap_seen;
        for (int v = 0; v < 32; v++) begin
            write_word(16'h0020 | 16'(v));
            wait_applied(wrap_seen);
            tick(25);
            check(int'(rd_data[4:0]) == fold(v), "R5 folded readback",
                  int'(rd_data[4:0]), fold(v));
            check(rise_off == fold(v) % 10, "R4 rise offset",
                  rise_off, fold(v) % 10);
            check(hi_len == 5 && lo_len == 5, "R2 duty after shift",
                  hi_len * 10 + lo_len, 55);
        end
    endtask

    task automatic test_no_apply();
        bit wrap_seen;
        write_word(16'h0023);
        wait_applied(wrap_seen);
        tick(25);
        write_word(16'h0007);
        tick(40);
        check(rise_off == 3, "R6 phase unchanged", rise_off, 3);
        check(rd_data[4:0] == 5'd7, "R6 stored field updated", int'(rd_data[4:0]), 7);
        check(rd_data[5] == 1'b0, "R6 no pending", int'(rd_data[5]), 0);
    endtask

    task automatic test_reserved();
        bit wrap_seen;
        write_word(16'hFFE2);
        check(rd_data[15:6] == 10'd0, "R8 reserved bits", int'(rd_data[15:6]), 0);
        wait_applied(wrap_seen);
        tick(25);
        check(rd_data[15:6] == 10'd0, "R8 reserved after apply", int'(rd_data[15:6]), 0);
        check(rise_off == 2, "R8 phase field still used", rise_off, 2);
    endtask

    initial begin
        test_reset();
        test_sync_rate();
        test_apply_timing();
        test_sweep();
        test_no_apply();
        test_reserved();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule